// File: doc/BRIEF.md
# Prescaled Interval Timer with Selectable Wrap Boundary

This block is an 8-bit up-counting interval timer. Each count step comes either from a prescaled internal clock or from rising edges on an external event pin. Two internal strobe sources are available: a CPU-rate clock enable and an oscillator-rate clock enable. A 3-bit rate code selects a power-of-two divide for the chosen source. After each full divide period the count advances by one.

The counter wraps at a boundary of 256, 64, 32 or 16, set by three mode pins. Only the count bits below the boundary take part in counting and wrap detection. The bits above it are kept as written and otherwise ignored. On a wrap the counter loads a value that software has placed in a separate reload register, and a sticky interrupt flag is raised. To get an interval of T counting-clock periods, software writes N minus T into the count, where N is the active boundary. A small register port gives read and write access to the count, the reload value and the flag.

Top module: `prescaled_wrap_timer`

## Requirements
- R1: After reset the count, the reload value and the overflow flag all read 0, and `irq` is low.
- R2: Register addresses are 0 for the count, 1 for the reload value and 2 for the flag in bit 0, with the upper bits of that read reading 0. Address 3 reads as the count. A write takes effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `rd_addr`.
- R3: In timer mode, with `src_osc`=0 and rate code k, the count advances once per 256>>k cycles in which `cpu_ce` is high. With `src_osc`=1 it advances once per 128>>k cycles in which `osc_ce` is high. The count updates at the edge that closes the last strobe cycle of each period.
- R4: The boundary N is 256 when `pwm_mode`=0 or `evt_mode`=1. Otherwise `{aload, out_en}` selects it: 00 gives 256, 01 gives 64, 10 gives 32 and 11 gives 16.
- R5: When N is below 256, the count bits at and above log2(N) do not change on a step and have no effect on wrap detection.
- R6: A step taken while the low log2(N) count bits equal N−1 loads the count from the reload register and sets the flag.
- R7: The flag stays set until bit 0 of a write to address 2 is 1. A write of 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: A write to the count in the same cycle as a step wins. The count takes the written value and the flag is not set by that step.
- R9: When `evt_mode`=1, each rising edge of `evt_in` advances the count by one. The count changes at the third rising clock edge, counting the first edge that samples `evt_in` high.
- R10: While `en`=0 the count changes only through writes. The prescaler restarts, so a full divide period is needed after `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Timer enable |
| src_osc | input | 1 | Strobe source: 0 CPU-rate, 1 oscillator-rate |
| rate | input | 3 | Prescale rate code |
| cpu_ce | input | 1 | CPU-rate clock enable strobe |
| osc_ce | input | 1 | Oscillator-rate clock enable strobe |
| evt_mode | input | 1 | Count external event edges instead of prescaler ticks |
| evt_in | input | 1 | External event input, asynchronous |
| pwm_mode | input | 1 | Boundary selection enable |
| aload | input | 1 | Boundary select, upper bit |
| out_en | input | 1 | Boundary select, lower bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Sticky overflow flag |

## Verification
A write, a prescaler tick or a wrap in one cycle shows up on `rd_data` and `irq` right after the next rising edge. An event-pin rise shows up only after the third edge that follows, because it first passes two synchronizer stages and an edge register. The bench holds a cycle-level reference model that updates on each rising edge from the same inputs. It compares one nanosecond after that edge, and the directed checks count exactly those edges before they sample. Inputs change only on falling edges. Mode and rate are reconfigured only while `en` is low, so the phase of the prescale period is always defined.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SH_W   = 4;

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd2;

  // log2 of the prescale divide: CPU source 256>>k, oscillator source 128>>k
  function automatic logic [SH_W-1:0] div_shift(input logic src_osc,
                                                input logic [RATE_W-1:0] rate);
    logic [SH_W-1:0] base;
    base = src_osc ? SH_W'(7) : SH_W'(8);
    return base - SH_W'(rate);
  endfunction

  // mask of the count bits that take part in counting for the active boundary
  function automatic logic [CNT_W-1:0] wrap_mask(input logic evt_mode,
                                                 input logic pwm_mode,
                                                 input logic aload,
                                                 input logic out_en);
    logic [CNT_W-1:0] m;
    if (evt_mode || !pwm_mode) begin
      m = '1;
    end else begin
      unique case ({aload, out_en})
        2'b00:   m = CNT_W'(8'hFF);
        2'b01:   m = CNT_W'(8'h3F);
        2'b10:   m = CNT_W'(8'h1F);
        default: m = CNT_W'(8'h0F);
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/pwt_prescaler.sv
module pwt_prescaler #(
  parameter int unsigned PW   = 8,
  parameter int unsigned SH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            strobe,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  logic [PW-1:0] pre_q;
  logic [PW:0]   one_sh;
  logic [PW-1:0] period_mask;

  assign one_sh      = (PW+1)'(1) << shift;
  assign period_mask = PW'(one_sh - (PW+1)'(1));
  assign tick        = en && strobe && ((pre_q & period_mask) == period_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!en)    pre_q <= '0;
    else if (strobe) pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/pwt_event_sync.sv
module pwt_event_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], evt_in};
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] mask,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count_q,
  output logic          wrap_ev
);
  logic at_top;
  logic [CW-1:0] low_next;

  assign at_top   = (count_q & mask) == mask;
  assign wrap_ev  = step && !wr_cnt && at_top;
  assign low_next = (count_q + CW'(1)) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (wr_cnt)  count_q <= wr_data;
    else if (wrap_ev) count_q <= reload;
    else if (step)    count_q <= (count_q & ~mask) | low_next;
  end
endmodule

// File: rtl/prescaled_wrap_timer.sv
module prescaled_wrap_timer
  import pwt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              src_osc,
  input  logic [RATE_W-1:0] rate,
  input  logic              cpu_ce,
  input  logic              osc_ce,
  input  logic              evt_mode,
  input  logic              evt_in,
  input  logic              pwm_mode,
  input  logic              aload,
  input  logic              out_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic [CNT_W-1:0] mask;
  logic [SH_W-1:0]  shift;
  logic             src_strobe;
  logic             tick;
  logic             evt_rise;
  logic             step_ev;
  logic             wrap_ev;
  logic             wr_cnt;
  logic             wr_rel;
  logic             clr_flag;

  assign shift      = div_shift(src_osc, rate);
  assign mask       = wrap_mask(evt_mode, pwm_mode, aload, out_en);
  assign src_strobe = src_osc ? osc_ce : cpu_ce;
  assign wr_cnt     = wr_en && (wr_addr == A_COUNT);
  assign wr_rel     = wr_en && (wr_addr == A_RELOAD);
  assign clr_flag   = wr_en && (wr_addr == A_FLAG) && wr_data[0];
  assign step_ev    = en && (evt_mode ? evt_rise : tick);

  pwt_prescaler #(.PW(CNT_W), .SH_W(SH_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .strobe(src_strobe),
    .shift(shift), .tick(tick)
  );

  pwt_event_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .rise(evt_rise)
  );

  pwt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_ev), .mask(mask),
    .wr_cnt(wr_cnt), .wr_data(wr_data), .reload(reload_q),
    .count_q(count_q), .wrap_ev(wrap_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reload_q <= '0;
    else if (wr_rel) reload_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_ev)  flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

  always_comb begin
    unique case (rd_addr)
      A_RELOAD: rd_data = reload_q;
      A_FLAG:   rd_data = {{(CNT_W-1){1'b0}}, flag_q};
      default:  rd_data = count_q;
    endcase
  end

  assign irq = flag_q;
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          wr_cnt,
  input logic [CW-1:0] wr_data,
  input logic          clr_flag,
  input logic          src_strobe,
  input logic          tick,
  input logic          step_ev,
  input logic          wrap_ev,
  input logic [CW-1:0] mask,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] reload_q,
  input logic          flag_q
);
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count_q == $past(wr_data));

  p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (count_q == $past(reload_q)) && flag_q);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_flag |=> flag_q);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag && !wrap_ev |=> !flag_q);

  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev && !wrap_ev && !wr_cnt |=>
      ((count_q & ~$past(mask)) == ($past(count_q) & ~$past(mask))) &&
      ((count_q & $past(mask)) == (($past(count_q) + CW'(1)) & $past(mask))));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !wr_cnt |=> count_q == $past(count_q));

  p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> src_strobe && en);
endmodule

bind prescaled_wrap_timer pwt_checker #(.CW(pwt_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_cnt(wr_cnt), .wr_data(wr_data),
  .clr_flag(clr_flag), .src_strobe(src_strobe), .tick(tick),
  .step_ev(step_ev), .wrap_ev(wrap_ev), .mask(mask), .count_q(count_q),
  .reload_q(reload_q), .flag_q(flag_q)
);

// File: tb/prescaled_wrap_timer_bench.sv
module prescaled_wrap_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 0, src_osc = 0, cpu_ce = 0, osc_ce = 0;
  logic [2:0] rate = 0;
  logic       evt_mode = 0, evt_in = 0, pwm_mode = 0, aload = 0, out_en = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       irq;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string phase = "R1 reset";

  always #2 clk = ~clk;

  prescaled_wrap_timer u_prescaled_wrap_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .src_osc(src_osc), .rate(rate),
    .cpu_ce(cpu_ce), .osc_ce(osc_ce), .evt_mode(evt_mode), .evt_in(evt_in),
    .pwm_mode(pwm_mode), .aload(aload), .out_en(out_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic int f_div(input logic s, input logic [2:0] k);
    return s ? (128 >> k) : (256 >> k);
  endfunction

  function automatic int f_bound(input logic ev, input logic pw, input logic a, input logic o);
    if (ev || !pw) return 256;
    case ({a, o})
      2'b00: return 256;
      2'b01: return 64;
      2'b10: return 32;
      default: return 16;
    endcase
  endfunction

  // reference model
  logic [7:0] m_cnt, m_rel;
  logic       m_flag, m_s1, m_s2, m_s3;
  int         m_ps;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ps = 0;
    end else begin
      automatic bit edge_now = m_s2 && !m_s3;
      automatic bit tk = 0, setf = 0, stp;
      automatic bit stb = src_osc ? osc_ce : cpu_ce;
      automatic int n = f_bound(evt_mode, pwm_mode, aload, out_en);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
      if (!en) m_ps = 0;
      else if (stb) begin
        if (m_ps == f_div(src_osc, rate) - 1) begin tk = 1; m_ps = 0; end
        else m_ps++;
      end
      stp = en && (evt_mode ? edge_now : tk);
      if (wr_en && wr_addr == 2'd0) m_cnt = wr_data;
      else if (stp) begin
        if (int'(m_cnt) % n == n - 1) begin m_cnt = m_rel; setf = 1; end
        else m_cnt = m_cnt + 8'd1;
      end
      if (wr_en && wr_addr == 2'd1) m_rel = wr_data;
      if (setf) m_flag = 1;
      else if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_flag = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      automatic logic [7:0] e;
      chk({phase, " model irq"}, irq, m_flag);
      case (rd_addr)
        2'd1: e = m_rel;
        2'd2: e = {7'd0, m_flag};
        default: e = m_cnt;
      endcase
      chk({phase, " model rd_data"}, rd_data, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] e);
    @(negedge clk); rd_addr = a; #1;
    chk(tag, rd_data, e);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd_chk("R1 count", 0, 8'h00);
    rd_chk("R1 reload", 1, 8'h00);
    rd_chk("R1 flag", 2, 8'h00);
    chk("R1 irq", irq, 0);
    // R2
    phase = "R2 regs";
    wr(1, 8'h33); wr(0, 8'hFE);
    rd_chk("R2 reload", 1, 8'h33);
    rd_chk("R2 count", 0, 8'hFE);
    // R4/R5/R6: boundary 16, upper bits set, osc /1
    phase = "R4/R5/R6 wrap16";
    @(negedge clk);
    pwm_mode = 1; aload = 1; out_en = 1; src_osc = 1; rate = 7; osc_ce = 1; en = 1;
    @(posedge clk); #1 chk("R5 step keeps upper bits", rd_data, 8'hFF);
    @(posedge clk); #1 chk("R4/R6 wrap at 16 reloads", rd_data, 8'h33);
    chk("R6 flag set", irq, 1);
    @(negedge clk); en = 0;
    // R7
    phase = "R7 flag";
    wr(2, 8'h00); chk("R7 write 0 keeps flag", irq, 1);
    wr(2, 8'h01); chk("R7 write 1 clears", irq, 0);
    // R10 hold while disabled
    phase = "R10 idle";
    repeat (5) @(negedge clk);
    rd_chk("R10 count held", 0, 8'h33);
    // R3 CPU source rate 6 -> /4
    phase = "R3 divide";
    @(negedge clk); pwm_mode = 0; src_osc = 0; rate = 6; cpu_ce = 1; en = 1;
    repeat (3) @(posedge clk);
    #1 chk("R3 no step before period", rd_data, 8'h33);
    @(posedge clk); #1 chk("R3 step after four strobes", rd_data, 8'h34);
    @(negedge clk); en = 0;
    // R8 write beats wrap
    phase = "R8 priority";
    wr(0, 8'hFF);
    @(negedge clk); src_osc = 1; rate = 7; en = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h80;
    @(posedge clk); #1 chk("R8 write wins", rd_data, 8'h80);
    chk("R8 no flag", irq, 0);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1 chk("R8 counting resumes", rd_data, 8'h81);
    @(negedge clk); en = 0;
    // R9 event latency
    phase = "R9 event";
    wr(0, 8'h10);
    @(negedge clk); evt_mode = 1; en = 1; evt_in = 1;
    repeat (2) @(posedge clk);
    #1 chk("R9 not yet", rd_data, 8'h10);
    @(posedge clk); #1 chk("R9 third edge", rd_data, 8'h11);
    @(negedge clk); evt_in = 0; en = 0; evt_mode = 0;
    repeat (4) @(negedge clk);
    // random segments
    phase = "R3/R4/R5/R6/R7/R8/R9/R10 random";
    for (int seg = 0; seg < 30; seg++) begin
      @(negedge clk);
      en = 0; wr_en = 0;
      src_osc = $urandom % 2;
      rate = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(5 + $urandom % 3);
      evt_mode = ($urandom % 4 == 0);
      pwm_mode = $urandom % 2; aload = $urandom % 2; out_en = $urandom % 2;
      wr(0, 8'($urandom)); wr(1, 8'($urandom));
      @(negedge clk); en = 1;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        cpu_ce = ($urandom % 4 != 0);
        osc_ce = ($urandom % 4 != 0);
        if ($urandom % 5 == 0) evt_in = ~evt_in;
        wr_en = ($urandom % 16 == 0);
        wr_addr = 2'($urandom % 3);
        wr_data = 8'($urandom);
        rd_addr = 2'($urandom % 4);
        if (c > 190) wr_en = 0;
      end
    end
    @(negedge clk); wr_en = 0; en = 0;
    @(negedge clk);
    finish_run();
  end
endmodule